// File: doc/BRIEF.md
# Exception Cause and Vector Selector

This block sits in front of the instruction fetch logic of a 32-bit processor core. Each cycle it collects the pending exception requests: the two reset inputs, the machine-check sources, the data and instruction storage faults, the alignment fault and the external interrupt pin. It picks one of them by a fixed priority and reports it with a one-cycle take strobe, a 20-bit vector offset and a 3-bit cause code. The fetch logic redirects to the offset when it sees the strobe.

Some requests are qualified before they count. A bus transfer error counts only while a data transfer is in flight. The external interrupt counts only while the block's own interrupt-enable bit is set. Offsets sit on a 0x100 grid: the cause code is the offset divided by 0x100, and offset zero is never produced. The enable bit is set by a request from the core and cleared by the block whenever it takes a non-reset exception. This keeps an interrupt line that is still asserted from firing again straight away.

Either reset input resets the block asynchronously. Release is synchronised to the clock, and once it completes the block reports the system reset exception itself.

Top module: `exc_vector_select`

## Requirements
- R1: While `soft_rst` or `hard_rst` is high, `take_o` is 0, `vec_o` is 0x00100, `cause_o` is 1 and `irq_en_o` is 0, whatever the other inputs do.
- R2: After both reset inputs have gone low, `take_o` is high for exactly one cycle, following the second rising edge, with `vec_o` = 0x00100 and `cause_o` = 1. Other requests and `irq_en_set` have no effect before that edge.
- R3: A machine check (`vec_o` 0x00200, `cause_o` 2) is raised by `mchk_pin`, by any bit of `parity_err`, or by `bus_err` while `data_xfer` is high. `bus_err` with `data_xfer` low raises nothing.
- R4: `dsi_req` gives `vec_o` 0x00300 with `cause_o` 3, `isi_req` gives 0x00400 with 4, and `align_req` gives 0x00600 with 6.
- R5: `ext_irq` gives `vec_o` 0x00500 with `cause_o` 5, but only when `irq_en_o` is 1 before the sampling edge. Otherwise it raises nothing.
- R6: When several requests are present at one edge, the winner is chosen in this order: machine check, instruction storage, data storage, alignment, external interrupt.
- R7: A request sampled at rising edge k makes `take_o` high after edge k, for that one cycle. On edges with no request, `take_o` returns to 0 while `vec_o` and `cause_o` keep their last values.
- R8: Taking any non-reset exception clears `irq_en_o` at the same edge, even if `irq_en_set` is high. At an edge where nothing is taken, `irq_en_set` = 1 sets `irq_en_o`.
- R9: `vec_o` is never 0x00000, and its low 8 bits are always zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| soft_rst | input | 1 | Soft reset request, active high, asynchronous |
| hard_rst | input | 1 | Hard reset request, active high, asynchronous |
| bus_err | input | 1 | Bus transfer error |
| data_xfer | input | 1 | A data bus transfer is in flight |
| mchk_pin | input | 1 | Machine-check input |
| parity_err | input | PAR_W | Address and data parity error flags |
| dsi_req | input | 1 | Data storage fault request |
| isi_req | input | 1 | Instruction storage fault request |
| align_req | input | 1 | Alignment fault request |
| ext_irq | input | 1 | External interrupt pin |
| irq_en_set | input | 1 | Request from the core to set the interrupt-enable bit |
| take_o | output | 1 | One-cycle strobe: an exception is taken |
| vec_o | output | 20 | Vector offset of the last exception taken |
| cause_o | output | 3 | Cause code of the last exception taken (offset / 0x100) |
| irq_en_o | output | 1 | Interrupt-enable bit |

## Verification
The bench goes after the qualifier corners. A bus error outside a data transfer must be ignored, and so must an interrupt while the enable bit is clear. A design that dropped either qualifier would report a spurious machine check or interrupt. The bench also holds the interrupt pin high across the edge where it is taken, which catches a design that forgets to clear the enable bit and would strobe on every cycle. It sets and takes in the same cycle, which catches a design that lets the set win. It pairs every two neighbouring priorities, so a swapped priority order shows up as the wrong cause. Last, it keeps requests asserted through a reset and through the release window, which catches a design that reports an exception while reset is held or takes the reset strobe on the wrong edge.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int VEC_W   = 20;
  localparam int CAUSE_W = 3;
  localparam int N_SRC   = 5;   // qualified non-reset sources
  localparam int SLOT_W  = $clog2(N_SRC);

  typedef enum logic [CAUSE_W-1:0] {
    C_NONE  = 3'd0,
    C_RESET = 3'd1,
    C_MCHK  = 3'd2,
    C_DSI   = 3'd3,
    C_ISI   = 3'd4,
    C_EXT   = 3'd5,
    C_ALIGN = 3'd6
  } cause_e;

  // Offset = cause * 0x100
  function automatic logic [VEC_W-1:0] vec_of(cause_e c);
    logic [VEC_W-1:0] v;
    v = '0;
    v[8 +: CAUSE_W] = c;
    return v;
  endfunction

  // Priority slot (0 = highest) to cause code
  function automatic cause_e cause_of_slot(logic [SLOT_W-1:0] s);
    case (s)
      3'd0:    return C_MCHK;
      3'd1:    return C_ISI;
      3'd2:    return C_DSI;
      3'd3:    return C_ALIGN;
      default: return C_EXT;
    endcase
  endfunction
endpackage

// File: rtl/exc_rst_sync.sv
module exc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_any,
  output logic hold_o,     // reset still in effect
  output logic release_o   // last cycle of hold: take reset at next edge
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or posedge rst_any) begin
    if (rst_any) sh_q <= '1;
    else         sh_q <= {sh_q[STAGES-2:0], 1'b0};
  end

  assign hold_o    = sh_q[STAGES-1];
  assign release_o = sh_q[STAGES-1] & ~sh_q[STAGES-2];
endmodule

// File: rtl/exc_cause_qual.sv
module exc_cause_qual
  import exc_pkg::*;
#(
  parameter int PAR_W = 2
) (
  input  logic             bus_err,
  input  logic             data_xfer,
  input  logic             mchk_pin,
  input  logic [PAR_W-1:0] parity_err,
  input  logic             dsi_req,
  input  logic             isi_req,
  input  logic             align_req,
  input  logic             ext_irq,
  input  logic             irq_en,
  output logic             mc_req_o,
  output logic [N_SRC-1:0] req_o    // bit index = priority slot
);
  assign mc_req_o = mchk_pin | (bus_err & data_xfer) | (|parity_err);

  assign req_o[0] = mc_req_o;
  assign req_o[1] = isi_req;
  assign req_o[2] = dsi_req;
  assign req_o[3] = align_req;
  assign req_o[4] = ext_irq & irq_en;
endmodule

// File: rtl/exc_prio_pick.sv
module exc_prio_pick
  import exc_pkg::*;
(
  input  logic [N_SRC-1:0]  req,
  output logic              valid_o,
  output logic [SLOT_W-1:0] slot_o
);
  always_comb begin
    slot_o = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (req[i]) slot_o = SLOT_W'(i);
    end
  end
  assign valid_o = |req;
endmodule

// File: rtl/exc_vector_select.sv
module exc_vector_select
  import exc_pkg::*;
#(
  parameter int PAR_W       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             soft_rst,
  input  logic             hard_rst,
  input  logic             bus_err,
  input  logic             data_xfer,
  input  logic             mchk_pin,
  input  logic [PAR_W-1:0] parity_err,
  input  logic             dsi_req,
  input  logic             isi_req,
  input  logic             align_req,
  input  logic             ext_irq,
  input  logic             irq_en_set,
  output logic             take_o,
  output logic [VEC_W-1:0] vec_o,
  output logic [CAUSE_W-1:0] cause_o,
  output logic             irq_en_o
);
  // Named internal events
  logic              rst_any;
  logic              rst_hold;
  logic              rst_release;
  logic              mc_req;
  logic [N_SRC-1:0]  req_vec;
  logic              win_valid;
  logic [SLOT_W-1:0] win_slot;
  cause_e            win_cause;

  logic              take_q;
  logic [VEC_W-1:0]  vec_q;
  cause_e            cause_q;
  logic              ie_q;

  assign rst_any = soft_rst | hard_rst;

  exc_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_any   (rst_any),
    .hold_o    (rst_hold),
    .release_o (rst_release)
  );

  exc_cause_qual #(.PAR_W(PAR_W)) u_qual (
    .bus_err    (bus_err),
    .data_xfer  (data_xfer),
    .mchk_pin   (mchk_pin),
    .parity_err (parity_err),
    .dsi_req    (dsi_req),
    .isi_req    (isi_req),
    .align_req  (align_req),
    .ext_irq    (ext_irq),
    .irq_en     (ie_q),
    .mc_req_o   (mc_req),
    .req_o      (req_vec)
  );

  exc_prio_pick u_pick (
    .req     (req_vec),
    .valid_o (win_valid),
    .slot_o  (win_slot)
  );

  assign win_cause = cause_of_slot(win_slot);

  always_ff @(posedge clk or posedge rst_any) begin
    if (rst_any) begin
      take_q  <= 1'b0;
      vec_q   <= vec_of(C_RESET);
      cause_q <= C_RESET;
      ie_q    <= 1'b0;
    end else if (rst_release) begin
      take_q  <= 1'b1;
      vec_q   <= vec_of(C_RESET);
      cause_q <= C_RESET;
      ie_q    <= 1'b0;
    end else if (rst_hold) begin
      take_q  <= 1'b0;
    end else if (win_valid) begin
      take_q  <= 1'b1;
      vec_q   <= vec_of(win_cause);
      cause_q <= win_cause;
      ie_q    <= 1'b0;
    end else begin
      take_q  <= 1'b0;
      if (irq_en_set) ie_q <= 1'b1;
    end
  end

  assign take_o   = take_q;
  assign vec_o    = vec_q;
  assign cause_o  = cause_q;
  assign irq_en_o = ie_q;

  // Assertions
  AST_VEC_NONZERO: assert property (@(posedge clk) disable iff (rst_any) vec_q != '0); // R9
  AST_VEC_GRID: assert property (@(posedge clk) disable iff (rst_any) vec_q[7:0] == 8'h00); // R9
  AST_EXT_GATED: assert property (@(posedge clk) disable iff (rst_any) (take_q && cause_q == C_EXT) |-> $past(ie_q)); // R5
  AST_IE_CLEARED: assert property (@(posedge clk) disable iff (rst_any) (take_q && cause_q != C_RESET) |-> !ie_q); // R8
  AST_MCHK_WINS: assert property (@(posedge clk) disable iff (rst_any) (!rst_hold && mc_req) |=> (take_q && cause_q == C_MCHK)); // R6
  AST_HELD_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst_any) !take_q |-> ($stable(vec_q) && $stable(cause_q))); // R7
  AST_QUIET_IN_HOLD: assert property (@(posedge clk) disable iff (rst_any) (rst_hold && !rst_release) |=> !take_q); // R2
endmodule

// File: tb/tb_exc_vector_select.sv
module tb_exc_vector_select;
  logic        clk = 1'b0;
  logic        soft_rst = 1'b0, hard_rst = 1'b1;
  logic        bus_err = 0, data_xfer = 0, mchk_pin = 0;
  logic [1:0]  parity_err = 0;
  logic        dsi_req = 0, isi_req = 0, align_req = 0, ext_irq = 0, irq_en_set = 0;
  logic        take_o;
  logic [19:0] vec_o;
  logic [2:0]  cause_o;
  logic        irq_en_o;

  exc_vector_select dut (
    .clk(clk), .soft_rst(soft_rst), .hard_rst(hard_rst),
    .bus_err(bus_err), .data_xfer(data_xfer), .mchk_pin(mchk_pin),
    .parity_err(parity_err), .dsi_req(dsi_req), .isi_req(isi_req),
    .align_req(align_req), .ext_irq(ext_irq), .irq_en_set(irq_en_set),
    .take_o(take_o), .vec_o(vec_o), .cause_o(cause_o), .irq_en_o(irq_en_o)
  );

  always #4 clk = ~clk;   // 125 MHz

  typedef struct {
    logic        take;
    logic [19:0] vec;
    logic [2:0]  cause;
    logic        ie;
    string       tag;
  } exp_t;

  exp_t q[$];
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // bench model state
  logic [19:0] m_vec = 20'h00100;
  logic [2:0]  m_cause = 3'd1;
  logic        m_ie = 1'b0;

  task automatic compare(exp_t e);
    n_chk++;
    if (take_o !== e.take || vec_o !== e.vec || cause_o !== e.cause || irq_en_o !== e.ie) begin
      n_fail++;
      $display("FAIL %s: actual take=%0b vec=%05h cause=%0d ie=%0b expected take=%0b vec=%05h cause=%0d ie=%0b",
               e.tag, take_o, vec_o, cause_o, irq_en_o, e.take, e.vec, e.cause, e.ie);
    end
  endtask

  task automatic push(logic t, logic [19:0] v, logic [2:0] c, logic ie, string tag);
    exp_t e;
    e.take = t; e.vec = v; e.cause = c; e.ie = ie; e.tag = tag;
    q.push_back(e);
  endtask

  // monitor: after each rising edge, compare with the oldest expectation
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) compare(q.pop_front());
    end
  end

  task automatic clear_inputs();
    bus_err = 0; data_xfer = 0; mchk_pin = 0; parity_err = 0;
    dsi_req = 0; isi_req = 0; align_req = 0; ext_irq = 0; irq_en_set = 0;
  endtask

  // driver: one cycle of stimulus, expectation from the requirements
  task automatic step(string tag, bit mc, bit be, bit dx, bit [1:0] par,
                      bit d, bit i, bit a, bit e, bit ies);
    bit mcq, extq, tk;
    logic [2:0] c;
    @(negedge clk);
    mchk_pin = mc; bus_err = be; data_xfer = dx; parity_err = par;
    dsi_req = d; isi_req = i; align_req = a; ext_irq = e; irq_en_set = ies;
    mcq  = mc | (be & dx) | (|par);
    extq = e & m_ie;
    tk = 1; c = 0;
    if (mcq)       c = 3'd2;
    else if (i)    c = 3'd4;
    else if (d)    c = 3'd3;
    else if (a)    c = 3'd6;
    else if (extq) c = 3'd5;
    else           tk = 0;
    if (tk) begin
      m_cause = c;
      m_vec   = {9'd0, c, 8'h00};
      m_ie    = 0;
    end else if (ies) begin
      m_ie = 1;
    end
    push(tk, m_vec, m_cause, m_ie, tag);
  endtask

  task automatic idle(string tag);
    step(tag, 0, 0, 0, 2'b00, 0, 0, 0, 0, 0);
  endtask

  // requests held during release must be ignored until the reset strobe
  task automatic release_reset(string tag);
    @(negedge clk);
    soft_rst = 0; hard_rst = 0;
    mchk_pin = 1; irq_en_set = 1; ext_irq = 1;
    push(0, 20'h00100, 3'd1, 0, {tag, " R2 first edge quiet"});
    @(negedge clk);
    push(1, 20'h00100, 3'd1, 0, {tag, " R2 reset strobe"});
    m_vec = 20'h00100; m_cause = 3'd1; m_ie = 0;
    step({tag, " R3 pin after release"}, 1, 0, 0, 2'b00, 0, 0, 0, 1, 1);
    idle({tag, " R7 idle after"});
  endtask

  task automatic hold_check(string tag);
    exp_t e;
    #1;
    e.take = 0; e.vec = 20'h00100; e.cause = 3'd1; e.ie = 0; e.tag = tag;
    compare(e);
  endtask

  initial begin
    // R1: reset held with every request active
    mchk_pin = 1; dsi_req = 1; isi_req = 1; align_req = 1; ext_irq = 1; irq_en_set = 1;
    hold_check("R1 hard reset at start");
    repeat (3) @(negedge clk);
    hold_check("R1 hard reset held, requests active");
    soft_rst = 1;
    hard_rst = 0;
    @(negedge clk);
    hold_check("R1 soft reset held");
    clear_inputs();
    release_reset("boot");

    // R3 machine check sources
    step("R3 bus error without data transfer ignored", 0, 1, 0, 2'b00, 0, 0, 0, 0, 0);
    step("R3 bus error during data transfer", 0, 1, 1, 2'b00, 0, 0, 0, 0, 0);
    step("R3 address parity flag", 0, 0, 0, 2'b01, 0, 0, 0, 0, 0);
    step("R3 data parity flag", 0, 0, 0, 2'b10, 0, 0, 0, 0, 0);
    step("R3 data transfer alone ignored", 0, 0, 1, 2'b00, 0, 0, 0, 0, 0);
    // R4 single faults, R7 held values
    step("R4 data storage", 0, 0, 0, 2'b00, 1, 0, 0, 0, 0);
    idle("R7 offset held after data storage");
    step("R4 instruction storage", 0, 0, 0, 2'b00, 0, 1, 0, 0, 0);
    step("R4 alignment", 0, 0, 0, 2'b00, 0, 0, 1, 0, 0);
    step("R7 alignment held level takes again", 0, 0, 0, 2'b00, 0, 0, 1, 0, 0);
    idle("R7 idle keeps alignment offset");
    // R5 interrupt gating, R8 enable handling
    step("R5 interrupt with enable clear ignored", 0, 0, 0, 2'b00, 0, 0, 0, 1, 0);
    step("R8 set enable while interrupt pending", 0, 0, 0, 2'b00, 0, 0, 0, 1, 1);
    step("R5 interrupt taken with enable set", 0, 0, 0, 2'b00, 0, 0, 0, 1, 0);
    step("R8 enable cleared so held pin is ignored", 0, 0, 0, 2'b00, 0, 0, 0, 1, 0);
    step("R8 set enable", 0, 0, 0, 2'b00, 0, 0, 0, 0, 1);
    step("R8 take clears enable despite set", 0, 0, 0, 2'b00, 1, 0, 0, 0, 1);
    step("R8 set enable again", 0, 0, 0, 2'b00, 0, 0, 0, 0, 1);
    // R6 priority pairs
    step("R6 all requests, machine check wins", 1, 0, 0, 2'b00, 1, 1, 1, 1, 0);
    step("R6 instruction storage over data storage", 0, 0, 0, 2'b00, 1, 1, 0, 0, 0);
    step("R6 data storage over alignment", 0, 0, 0, 2'b00, 1, 0, 1, 0, 0);
    step("R6 set enable for next pair", 0, 0, 0, 2'b00, 0, 0, 0, 0, 1);
    step("R6 alignment over interrupt", 0, 0, 0, 2'b00, 0, 0, 1, 1, 0);
    step("R6 set enable", 0, 0, 0, 2'b00, 0, 0, 0, 0, 1);
    step("R6 interrupt lowest but alone wins", 0, 0, 0, 2'b00, 0, 0, 0, 1, 0);
    step("R6 parity machine check over instruction storage", 0, 0, 0, 2'b10, 0, 1, 0, 0, 0);
    idle("R9 idle");

    // R1 soft reset mid-run
    @(negedge clk);
    clear_inputs();
    soft_rst = 1; isi_req = 1; ext_irq = 1;
    hold_check("R1 soft reset mid-run");
    repeat (2) @(negedge clk);
    hold_check("R1 soft reset mid-run held");
    clear_inputs();
    release_reset("soft");

    repeat (3) @(posedge clk);
    #3;
    if (q.size() != 0) begin
      n_chk++; n_fail++;
      $display("FAIL R7: %0d expectations left unchecked, expected 0", q.size());
    end
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule